// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Routing Table

This block is the software-facing register front end of an I/O interrupt router. A small memory-mapped region holds two registers: a byte-wide select register and a 32-bit data window. Software writes a select value first. It then reads or writes the data window to reach the register named by that select value.

Three kinds of register sit behind the window:
- a 4-bit identification field;
- a read-only version word that also reports the pin count;
- one 64-bit routing entry per interrupt pin, reached as a low and a high 32-bit half.

The stored entry fields are exported to the delivery logic, which is outside this block. The delivery logic can raise an entry's remote-pending flag through a per-pin input. The block announces every accepted entry write with a one-cycle change pulse that carries the entry index. A separate per-pin strobe marks writes to the low half.

Top module: `irq_window_ctrl`

## Requirements
- R1: Only the low 8 bits of `bus_addr` are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. Reads of any other offset return 0, and writes to any other offset change nothing.
- R2: A write to the select register stores `bus_wdata[7:0]`. A read of it returns that byte in bits 7:0, with zeros above.
- R3: With select 0x00, the window reads the ID in bits 27:24 with all other bits 0, and a window write loads the ID from `bus_wdata[27:24]`. With select 0x02, the window reads the same value and writes are ignored.
- R4: With select 0x01, the window reads `NUM_PINS-1` in bits 23:16 and `VERSION` in bits 7:0, with all other bits 0. Writes are ignored.
- R5: For select values of 0x10 and above, the entry index is (select − 0x10) >> 1. Select bit 0 = 1 reaches entry bits 63:32, and select bit 0 = 0 reaches bits 31:0. Reads return the stored half, and writes replace it.
- R6: A select value of 0x03 to 0x0F, or an entry index of `NUM_PINS` or more, reads as 0xFFFFFFFF. A window write with such a select value changes no state and raises no pulse.
- R7: Entry bit 14 (remote-pending) is set by `set_remote[i]`. A low-half write always clears it, whatever the written bit 14 is, and this clear wins over a `set_remote` in the same cycle.
- R8: After reset, every entry reads 0x00010000 (low half) and 0x00000000 (high half), so every mask bit is 1. The select register and the ID are 0.
- R9: The exported fields follow the stored entry: vector = bits 7:0, level trigger = bit 15, mask = bit 16, remote-pending = bit 14, destination = bits 63:56.
- R10: In the cycle after an accepted entry write, `chg_valid` is 1 and `chg_index` holds the entry index, for exactly one cycle. `lo_wr_strobe[index]` pulses in that same cycle only for a low-half write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset; low 8 bits decoded |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| set_remote | input | NUM_PINS | Per-pin request to set remote-pending |
| ent_vector | output | 8*NUM_PINS | Vector field of each entry |
| ent_dest | output | 8*NUM_PINS | Destination field of each entry |
| ent_level | output | NUM_PINS | Trigger mode of each entry (1 = level) |
| ent_mask | output | NUM_PINS | Mask bit of each entry |
| ent_remote | output | NUM_PINS | Remote-pending bit of each entry |
| lo_wr_strobe | output | NUM_PINS | One-cycle pulse after a low-half write |
| chg_valid | output | 1 | One-cycle pulse after any accepted entry write |
| chg_index | output | IDX_W | Index of the entry that changed |

## Verification
The hardest case to reach is a low-half write and a `set_remote` pulse on the same entry in the same cycle, because only that cycle shows which of the two wins. The bench steers the select register onto an entry, drives both inputs together, and also writes a 1 in bit 14 to confirm that software cannot set the flag. It also writes the select register with values that just cross the table end (0x40, 0x41) and with values in the 0x03–0x0F gap. It then runs a long random mix of select values up to 0x5F, with aliased upper address bits, against a behavioural model.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

   localparam int ENT_W       = 64;
   localparam int HALF_W      = 32;
   localparam int B_VEC_LO    = 0;
   localparam int B_LEVEL     = 15;
   localparam int B_REMOTE    = 14;
   localparam int B_MASK      = 16;
   localparam int B_DEST_LO   = 56;

   localparam logic [7:0] OFF_SELECT = 8'h00;
   localparam logic [7:0] OFF_WINDOW = 8'h10;
   localparam logic [7:0] SEL_ID     = 8'h00;
   localparam logic [7:0] SEL_VER    = 8'h01;
   localparam logic [7:0] SEL_ARB    = 8'h02;
   localparam logic [7:0] SEL_TABLE  = 8'h10;

   typedef enum logic [2:0] {
      RK_ID,
      RK_VER,
      RK_ARB,
      RK_ENTRY,
      RK_BAD
   } reg_kind_e;

   localparam logic [ENT_W-1:0] ENT_RESET = 64'h1 << B_MASK;

endpackage

// File: rtl/irqw_decode.sv
module irqw_decode
   import irqw_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int NUM_PINS = 24,
   parameter int IDX_W    = 5
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        sel,
   output logic              sel_hit,
   output logic              win_hit,
   output reg_kind_e         kind,
   output logic [IDX_W-1:0]  ent_idx,
   output logic              ent_hi,
   output logic              sel_we,
   output logic              id_we,
   output logic              ent_we
);

   logic [7:0] off;
   logic [7:0] rel;
   logic [6:0] raw_idx;
   logic       in_table;

   assign off      = bus_addr[7:0];
   assign sel_hit  = (off == OFF_SELECT);
   assign win_hit  = (off == OFF_WINDOW);
   assign rel      = sel - SEL_TABLE;
   assign raw_idx  = rel[7:1];
   assign in_table = (sel >= SEL_TABLE) && (int'(raw_idx) < NUM_PINS);
   assign ent_hi   = sel[0];
   assign ent_idx  = in_table ? raw_idx[IDX_W-1:0] : '0;

   always_comb begin
      unique case (sel)
         SEL_ID:  kind = RK_ID;
         SEL_VER: kind = RK_VER;
         SEL_ARB: kind = RK_ARB;
         default: kind = in_table ? RK_ENTRY : RK_BAD;
      endcase
   end

   assign sel_we = bus_we && sel_hit;
   assign id_we  = bus_we && win_hit && (kind == RK_ID);
   assign ent_we = bus_we && win_hit && (kind == RK_ENTRY);

endmodule

// File: rtl/irqw_entry.sv
module irqw_entry
   import irqw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [HALF_W-1:0] wdata,
   input  logic              set_remote,
   output logic [ENT_W-1:0]  q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= ENT_RESET;
      end else begin
         if (we_hi) begin
            q[ENT_W-1:HALF_W] <= wdata;
         end
         if (we_lo) begin
            q[HALF_W-1:0] <= wdata & ~(32'h1 << B_REMOTE);
         end else if (set_remote) begin
            q[B_REMOTE] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/irqw_rdmux.sv
module irqw_rdmux
   import irqw_pkg::*;
#(
   parameter int         NUM_PINS = 24,
   parameter int         IDX_W    = 5,
   parameter logic [7:0] VERSION  = 8'h11
) (
   input  reg_kind_e                      kind,
   input  logic [IDX_W-1:0]               ent_idx,
   input  logic                           ent_hi,
   input  logic [3:0]                     id,
   input  logic [NUM_PINS-1:0][ENT_W-1:0] ents,
   output logic [HALF_W-1:0]              win_rdata
);

   localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

   logic [ENT_W-1:0] picked;

   assign picked = ents[ent_idx];

   always_comb begin
      unique case (kind)
         RK_ID, RK_ARB: win_rdata = {4'h0, id, 24'h0};
         RK_VER:        win_rdata = {8'h00, MAX_PIN, 8'h00, VERSION};
         RK_ENTRY:      win_rdata = ent_hi ? picked[ENT_W-1:HALF_W] : picked[HALF_W-1:0];
         default:       win_rdata = '1;
      endcase
   end

endmodule

// File: rtl/irq_window_ctrl.sv
module irq_window_ctrl
   import irqw_pkg::*;
#(
   parameter int         ADDR_W   = 12,
   parameter int         NUM_PINS = 24,
   parameter logic [7:0] VERSION  = 8'h11,
   localparam int        IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_PINS-1:0]   set_remote,
   output logic [8*NUM_PINS-1:0] ent_vector,
   output logic [8*NUM_PINS-1:0] ent_dest,
   output logic [NUM_PINS-1:0]   ent_level,
   output logic [NUM_PINS-1:0]   ent_mask,
   output logic [NUM_PINS-1:0]   ent_remote,
   output logic [NUM_PINS-1:0]   lo_wr_strobe,
   output logic                  chg_valid,
   output logic [IDX_W-1:0]      chg_index
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the 8 decoded offset bits");
   end
   if (NUM_PINS < 1 || NUM_PINS > 120) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..120 to fit the select byte");
   end

   logic [7:0]                     sel_q;
   logic [3:0]                     id_q;
   logic                           sel_hit, win_hit, sel_we, id_we, ent_we, ent_hi;
   reg_kind_e                      kind;
   logic [IDX_W-1:0]               ent_idx;
   logic [NUM_PINS-1:0][ENT_W-1:0] ents;
   logic [HALF_W-1:0]              win_rdata;

   irqw_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_PINS(NUM_PINS),
      .IDX_W   (IDX_W)
   ) u_dec (
      .bus_addr(bus_addr),
      .bus_we  (bus_we),
      .sel     (sel_q),
      .sel_hit (sel_hit),
      .win_hit (win_hit),
      .kind    (kind),
      .ent_idx (ent_idx),
      .ent_hi  (ent_hi),
      .sel_we  (sel_we),
      .id_we   (id_we),
      .ent_we  (ent_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (sel_we) sel_q <= bus_wdata[7:0];
         if (id_we)  id_q  <= bus_wdata[27:24];
      end
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic hit;
      assign hit = ent_we && (int'(ent_idx) == i);

      irqw_entry u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .we_lo     (hit && !ent_hi),
         .we_hi     (hit && ent_hi),
         .wdata     (bus_wdata),
         .set_remote(set_remote[i]),
         .q         (ents[i])
      );

      assign ent_vector[8*i +: 8] = ents[i][B_VEC_LO +: 8];
      assign ent_dest[8*i +: 8]   = ents[i][B_DEST_LO +: 8];
      assign ent_level[i]         = ents[i][B_LEVEL];
      assign ent_mask[i]          = ents[i][B_MASK];
      assign ent_remote[i]        = ents[i][B_REMOTE];

      always_ff @(posedge clk) begin
         if (!rst_n) lo_wr_strobe[i] <= 1'b0;
         else        lo_wr_strobe[i] <= hit && !ent_hi;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chg_valid <= 1'b0;
         chg_index <= '0;
      end else begin
         chg_valid <= ent_we;
         if (ent_we) chg_index <= ent_idx;
      end
   end

   irqw_rdmux #(
      .NUM_PINS(NUM_PINS),
      .IDX_W   (IDX_W),
      .VERSION (VERSION)
   ) u_rd (
      .kind     (kind),
      .ent_idx  (ent_idx),
      .ent_hi   (ent_hi),
      .id       (id_q),
      .ents     (ents),
      .win_rdata(win_rdata)
   );

   always_comb begin
      if (sel_hit)      bus_rdata = {24'h0, sel_q};
      else if (win_hit) bus_rdata = win_rdata;
      else              bus_rdata = '0;
   end

endmodule

// File: rtl/irqw_checker.sv
module irqw_checker #(
   parameter int ADDR_W   = 12,
   parameter int NUM_PINS = 24,
   parameter int IDX_W    = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [31:0]           bus_rdata,
   input logic [8*NUM_PINS-1:0] ent_vector,
   input logic [NUM_PINS-1:0]   ent_mask,
   input logic [NUM_PINS-1:0]   ent_remote,
   input logic [NUM_PINS-1:0]   lo_wr_strobe,
   input logic                  chg_valid,
   input logic [IDX_W-1:0]      chg_index
);

   AST_OTHER_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[7:0] != 8'h00 && bus_addr[7:0] != 8'h10) |-> (bus_rdata == 32'h0)); // R1

   AST_CHG_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      chg_valid |-> (int'(chg_index) < NUM_PINS)); // R10

   AST_LO_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lo_wr_strobe)); // R10

   AST_LO_STROBE_WITH_CHG: assert property (@(posedge clk) disable iff (!rst_n)
      (|lo_wr_strobe) |-> (chg_valid && lo_wr_strobe[chg_index])); // R10

   AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ent_mask) |-> (|lo_wr_strobe)); // R9

   AST_VECTOR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ent_vector) |-> (|lo_wr_strobe)); // R9

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_rp
      AST_REMOTE_CLEARED_BY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         lo_wr_strobe[i] |-> !ent_remote[i]); // R7
   end

endmodule

bind irq_window_ctrl irqw_checker #(
   .ADDR_W  (ADDR_W),
   .NUM_PINS(NUM_PINS),
   .IDX_W   (IDX_W)
) u_irqw_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_rdata   (bus_rdata),
   .ent_vector  (ent_vector),
   .ent_mask    (ent_mask),
   .ent_remote  (ent_remote),
   .lo_wr_strobe(lo_wr_strobe),
   .chg_valid   (chg_valid),
   .chg_index   (chg_index)
);

// File: tb/irq_window_ctrl_bench.sv
`timescale 1ns/1ps
module irq_window_ctrl_bench;

   localparam int         AW  = 12;
   localparam int         NP  = 24;
   localparam int         IW  = 5;
   localparam logic [7:0] VER = 8'h11;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic            bus_we = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NP-1:0]   set_remote = '0;
   logic [8*NP-1:0] ent_vector, ent_dest;
   logic [NP-1:0]   ent_level, ent_mask, ent_remote, lo_wr_strobe;
   logic            chg_valid;
   logic [IW-1:0]   chg_index;

   always #10 clk = ~clk;

   irq_window_ctrl #(.ADDR_W(AW), .NUM_PINS(NP), .VERSION(VER)) u_irq_window_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_remote(set_remote),
      .ent_vector(ent_vector), .ent_dest(ent_dest), .ent_level(ent_level),
      .ent_mask(ent_mask), .ent_remote(ent_remote), .lo_wr_strobe(lo_wr_strobe),
      .chg_valid(chg_valid), .chg_index(chg_index)
   );

   // behavioural model
   logic [63:0] m_ent [NP];
   logic [7:0]  m_sel;
   logic [3:0]  m_id;
   logic        m_chg;
   int          m_chg_idx;
   logic [NP-1:0] m_lo;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
      m_sel = 0; m_id = 0; m_chg = 0; m_chg_idx = 0; m_lo = '0;
   endtask

   // expected window read and which requirement it exercises
   task automatic model_read(input logic [AW-1:0] a, output logic [31:0] v, output string tag);
      int idx;
      if (a[7:0] == 8'h00) begin v = {24'h0, m_sel}; tag = "R2"; end
      else if (a[7:0] != 8'h10) begin v = 0; tag = "R1"; end
      else if (m_sel == 8'h00 || m_sel == 8'h02) begin v = {4'h0, m_id, 24'h0}; tag = "R3"; end
      else if (m_sel == 8'h01) begin v = {8'h0, 8'(NP-1), 8'h0, VER}; tag = "R4"; end
      else begin
         idx = (int'(m_sel) - 16) >>> 1;
         if (m_sel < 8'h10 || idx >= NP) begin v = 32'hFFFF_FFFF; tag = "R6"; end
         else begin
            v = m_sel[0] ? m_ent[idx][63:32] : m_ent[idx][31:0];
            tag = "R5";
         end
      end
   endtask

   task automatic model_clock(input logic [AW-1:0] a, input bit we, input logic [31:0] d, input logic [NP-1:0] rem);
      int idx;
      m_chg = 0; m_lo = '0;
      if (we && a[7:0] == 8'h10) begin
         if (m_sel == 8'h00) m_id = d[27:24];
         else if (m_sel >= 8'h10) begin
            idx = (int'(m_sel) - 16) >>> 1;
            if (idx < NP) begin
               m_chg = 1; m_chg_idx = idx;
               if (m_sel[0]) m_ent[idx][63:32] = d;
               else begin
                  m_ent[idx][31:0] = d & ~32'h4000;
                  m_lo[idx] = 1;
               end
            end
         end
      end
      for (int i = 0; i < NP; i++)
         if (rem[i] && !m_lo[i]) m_ent[i][14] = 1'b1;
      if (we && a[7:0] == 8'h00) m_sel = d[7:0];
   endtask

   task automatic compare_outputs();
      logic [8*NP-1:0] ev, ed;
      logic [NP-1:0] el, em, er;
      for (int i = 0; i < NP; i++) begin
         ev[8*i +: 8] = m_ent[i][7:0];
         ed[8*i +: 8] = m_ent[i][63:56];
         el[i] = m_ent[i][15];
         em[i] = m_ent[i][16];
         er[i] = m_ent[i][14];
      end
      check(ent_vector == ev && ent_dest == ed && ent_level == el && ent_mask == em,
            "R9 fields", {ent_vector, ent_mask}, {ev, em});
      check(ent_remote == er, "R7 remote", 192'(ent_remote), 192'(er));
      check(chg_valid == m_chg && (!m_chg || int'(chg_index) == m_chg_idx),
            "R10 change pulse", 192'({chg_valid, chg_index}), 192'({m_chg, 5'(m_chg_idx)}));
      check(lo_wr_strobe == m_lo, "R10 low strobe", 192'(lo_wr_strobe), 192'(m_lo));
   endtask

   // entered and left at a falling edge
   task automatic step(input logic [AW-1:0] a, input bit we, input logic [31:0] d, input logic [NP-1:0] rem);
      logic [31:0] ev;
      string tag;
      bus_addr = a; bus_we = we; bus_wdata = d; set_remote = rem;
      #1;
      model_read(a, ev, tag);
      check(bus_rdata == ev, {tag, " read"}, 192'(bus_rdata), 192'(ev));
      @(posedge clk);
      model_clock(a, we, d, rem);
      @(negedge clk);
      compare_outputs();
   endtask

   task automatic wsel(input logic [31:0] s);
      step(12'h000, 1, s, '0);
   endtask
   task automatic wwin(input logic [31:0] d);
      step(12'h010, 1, d, '0);
   endtask
   task automatic rwin();
      step(12'h010, 0, 32'h0, '0);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state seen through ports
      check(ent_mask == '1 && ent_remote == '0 && chg_valid == 0,
            "R8 reset outputs", 192'({ent_mask, ent_remote}), 192'({{NP{1'b1}}, {NP{1'b0}}}));
      step(12'h000, 0, 0, '0);
      wsel(32'h10); rwin();   // R8 entry 0 low = 0x00010000
      wsel(32'h11); rwin();   // R8 entry 0 high = 0
      // R4 version, write ignored
      wsel(32'h01); rwin(); wwin(32'hFFFF_FFFF); rwin();
      // R3 ID write and arbitration alias
      wsel(32'h00); wwin(32'hA500_0000); rwin();
      wsel(32'h02); rwin(); wwin(32'h0300_0000); rwin();
      wsel(32'h00); rwin();
      // R5 entry 1 halves, R9 fields
      wsel(32'h12); wwin(32'h0001_8031); rwin();
      wsel(32'h13); wwin(32'hAB00_0000); rwin();
      // R7 remote set, then cleared by low write that also tries to set bit 14
      step(12'h000, 0, 0, 24'h000002);
      wsel(32'h12); rwin();
      step(12'h010, 1, 32'h0000_4031, 24'h000002);
      rwin();
      // R6 out of range and gap
      wsel(32'h40); rwin(); wwin(32'h1234_5678);
      wsel(32'h41); rwin(); wwin(32'h1234_5678);
      wsel(32'h05); rwin(); wwin(32'h1234_5678);
      // last valid entry (R5)
      wsel(32'h3F); wwin(32'hCAFE_0000); rwin();
      // R1 other offsets and aliasing of upper address bits
      step(12'h020, 1, 32'hFFFF_FFFF, '0);
      step(12'h110, 0, 0, '0);
      step(12'hF04, 0, 0, '0);
      // R2 select keeps low byte
      wsel(32'hFFFF_FF3E); step(12'h100, 0, 0, '0);
      // random phase
      for (int k = 0; k < 4000; k++) begin
         logic [AW-1:0] a;
         logic [31:0]   d;
         int            r;
         r = $urandom_range(0, 9);
         d = $urandom();
         if (r < 3)      begin a = 12'h000; d[7:0] = 8'($urandom_range(0, 8'h5F)); end
         else if (r < 8) a = {4'($urandom_range(0, 15)), 8'h10};
         else            a = 12'($urandom());
         step(a, $urandom_range(0, 1) == 1, d,
              ($urandom_range(0, 3) == 0) ? NP'($urandom()) : '0);
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule